// File: doc/BRIEF.md
# Input Edge Capture Unit

This block watches an asynchronous event pin and copies the value of an external free-running counter into one of two capture registers when a chosen kind of edge appears on that pin. An edge-select code chooses rising edges, falling edges, both, or none. A sequence-select input chooses between two modes. In single mode the first qualifying edge fills capture register 1. In dual mode the first edge fills register 1 and the second fills register 2.

When the sequence completes, a capture flag is raised for interrupt logic elsewhere. Software lowers the flag with a one-cycle clear strobe, and the same strobe re-arms the sequence. Capture only works while the pin is configured as an input. The counter and the interrupt aggregation sit outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is held low at a clock edge, both capture registers read zero and the capture flag is 0 after that edge.
- R2: With edge code 1, a rising pin edge is a capture event and a falling edge is not.
- R3: With edge code 2, a falling pin edge is a capture event and a rising edge is not.
- R4: With edge code 3, both rising and falling pin edges are capture events.
- R5: With edge code 0, no pin edge is a capture event.
- R6: While the pin-direction input is 0 (pin driven as an output), no pin edge is a capture event, whatever the edge code.
- R7: Each pin change is taken through a two-flop synchroniser. A capture stores the counter value present at the third rising clock edge after the pin change. The flag rises at that same edge, and neither output changes before it.
- R8: In single mode (sequence select 0), the first event loads capture register 1 and sets the flag. Capture register 2 is left unchanged.
- R9: In dual mode (sequence select 1), the first event loads capture register 1 and leaves the flag at 0. The second event loads capture register 2 and sets the flag.
- R10: While the flag is set, further events change neither capture register.
- R11: A clear strobe makes the flag 0 at the next edge and re-arms the sequence, so the next event counts as a first event. An event that arrives in the same cycle as the strobe is dropped.
- R12: Capture registers keep their values between captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Free-running counter value |
| evt_pin_i | input | 1 | Asynchronous event pin |
| edge_sel_i | input | 2 | Edge code: 0 none, 1 rising, 2 falling, 3 both |
| second_sel_i | input | 1 | 0 single mode, 1 dual mode |
| pin_is_input_i | input | 1 | 1 when the pin is configured as an input |
| flag_clr_i | input | 1 | One-cycle flag clear and re-arm strobe |
| cap1_o | output | CNT_W | Capture register 1 |
| cap2_o | output | CNT_W | Capture register 2 |
| cap_flag_o | output | 1 | Capture-complete flag |

## Verification
A pin change reaches the outputs at the third rising clock edge after it: two edges pass through the synchroniser and one loads the capture register. The bench moves the pin on a falling clock edge and counts three rising edges. It then samples a little after the third edge and compares against the counter value it reads at that moment; its own counter only advances on falling edges, so that value is the one the block stored. One directed case also samples after the second edge to confirm that nothing has changed yet. The flag clear takes effect one edge after the strobe, and the bench places the strobe on the exact edge where an event lands so that the coincidence case is exercised.

// File: rtl/cap_pkg.sv
// Shared types for the edge capture unit.
package cap_pkg;
    // Edge-qualification code as seen on the configuration input
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    // Capture sequence position
    typedef enum logic [1:0] {
        SEQ_ARMED = 2'd0,
        SEQ_FIRST = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_e;

    localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/cap_pin_sync.sv
// Synchronises the asynchronous event pin and reports one-cycle rise and
// fall pulses. Assumes the pin is low while reset is applied.
module cap_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift chain: synchroniser stages plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], pin_i};
    end

    // Edge pulses from the synchronised level and its history
    always_comb begin
        rise_o =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
        fall_o = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
    end
endmodule

// File: rtl/cap_edge_qualify.sv
// Combinational filter: turns edge pulses into a capture event according
// to the edge code and pin direction. Assumes pulses are single-cycle.
module cap_edge_qualify
    import cap_pkg::*;
(
    input  edge_sel_e sel_i,
    input  logic      pin_in_i,
    input  logic      rise_i,
    input  logic      fall_i,
    output logic      evt_o
);
    // Select which edges count, then gate by pin direction
    always_comb begin
        logic hit;
        case (sel_i)
            EDGE_RISE: hit = rise_i;
            EDGE_FALL: hit = fall_i;
            EDGE_ANY:  hit = rise_i | fall_i;
            default:   hit = 1'b0;
        endcase
        evt_o = hit & pin_in_i;
    end
endmodule

// File: rtl/cap_sequencer.sv
// Tracks first/second event position, drives per-slot load enables and the
// completion flag. A clear strobe outranks a coincident event.
module cap_sequencer
    import cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_i,
    input  logic                 dual_i,
    input  logic                 clr_i,
    output logic [NUM_SLOTS-1:0] load_o,
    output logic                 flag_o
);
    seq_state_e state_q;

    // Sequence state and flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_ARMED;
            flag_o  <= 1'b0;
        end else if (clr_i) begin
            state_q <= SEQ_ARMED;
            flag_o  <= 1'b0;
        end else if (evt_i) begin
            case (state_q)
                SEQ_ARMED: begin
                    state_q <= dual_i ? SEQ_FIRST : SEQ_DONE;
                    flag_o  <= ~dual_i;
                end
                SEQ_FIRST: begin
                    state_q <= SEQ_DONE;
                    flag_o  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Load enable for the slot that the current event fills
    always_comb begin
        load_o = '0;
        if (evt_i && !clr_i) begin
            case (state_q)
                SEQ_ARMED: load_o[0] = 1'b1;
                SEQ_FIRST: load_o[1] = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/cap_hold_reg.sv
// One capture register: loads the counter value on enable, else holds.
module cap_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Load-or-hold storage
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/edge_capture_unit.sv
// Top of the edge capture unit: synchroniser, qualifier, sequencer and two
// capture registers. Assumes count_i is synchronous to clk.
module edge_capture_unit
    import cap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             evt_pin_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             second_sel_i,
    input  logic             pin_is_input_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cap1_o,
    output logic [CNT_W-1:0] cap2_o,
    output logic             cap_flag_o
);
    logic                 rise_p, fall_p, cap_evt;
    logic [NUM_SLOTS-1:0] slot_load;
    logic [CNT_W-1:0]     slot_q [NUM_SLOTS];

    cap_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(evt_pin_i),
        .rise_o(rise_p), .fall_o(fall_p)
    );

    cap_edge_qualify u_qual (
        .sel_i(edge_sel_e'(edge_sel_i)), .pin_in_i(pin_is_input_i),
        .rise_i(rise_p), .fall_i(fall_p), .evt_o(cap_evt)
    );

    cap_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .evt_i(cap_evt), .dual_i(second_sel_i),
        .clr_i(flag_clr_i), .load_o(slot_load), .flag_o(cap_flag_o)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        cap_hold_reg #(.W(CNT_W)) u_reg (
            .clk(clk), .rst_n(rst_n), .load_i(slot_load[g]),
            .d_i(count_i), .q_o(slot_q[g])
        );
    end

    assign cap1_o = slot_q[0];
    assign cap2_o = slot_q[1];
endmodule

// File: rtl/cap_checker.sv
// Temporal checks on the edge capture unit, attached by bind.
module cap_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       edge_sel_i,
    input logic             second_sel_i,
    input logic             pin_is_input_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] cap1_o,
    input logic [CNT_W-1:0] cap2_o,
    input logic             cap_flag_o,
    input logic             cap_evt
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (cap1_o == '0 && cap2_o == '0 && !cap_flag_o));

    p_code_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == 2'd0) |-> !cap_evt);

    p_pin_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_input_i |-> !cap_evt);

    p_single_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_flag_o && cap_evt && !flag_clr_i && !second_sel_i) |=> cap_flag_o);

    p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_o && !flag_clr_i) |=> ($stable(cap1_o) && $stable(cap2_o)));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr_i |=> !cap_flag_o);
endmodule

bind edge_capture_unit cap_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .edge_sel_i(edge_sel_i),
    .second_sel_i(second_sel_i), .pin_is_input_i(pin_is_input_i),
    .flag_clr_i(flag_clr_i), .cap1_o(cap1_o), .cap2_o(cap2_o),
    .cap_flag_o(cap_flag_o), .cap_evt(cap_evt)
);

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    // Row fields: [8:7] edge code, [6] dual, [5] pin input,
    // [4:3] cap1 source, [2:1] cap2 source (0 keep, 1 rise, 2 fall), [0] flag
    localparam logic [8:0] VEC [0:7] = '{
        {2'd1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1},   // R2 R8
        {2'd2, 1'b0, 1'b1, 2'd2, 2'd0, 1'b1},   // R3
        {2'd3, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1},   // R4 R10
        {2'd3, 1'b1, 1'b1, 2'd1, 2'd2, 1'b1},   // R4 R9
        {2'd1, 1'b1, 1'b1, 2'd1, 2'd0, 1'b0},   // R9
        {2'd0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},   // R5
        {2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},   // R6
        {2'd2, 1'b1, 1'b1, 2'd2, 2'd0, 1'b0}    // R3 R9 R11
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt = '0;
    logic             pin = 1'b0;
    logic [1:0]       sel = 2'd0;
    logic             dual = 1'b0;
    logic             dir = 1'b1;
    logic             clr = 1'b0;
    logic [CNT_W-1:0] cap1, cap2;
    logic             flag;
    int               checks = 0;
    int               fails = 0;
    logic [CNT_W-1:0] exp1 = '0;
    logic [CNT_W-1:0] exp2 = '0;

    edge_capture_unit #(.CNT_W(CNT_W)) i_edge_capture_unit (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .evt_pin_i(pin),
        .edge_sel_i(sel), .second_sel_i(dual), .pin_is_input_i(dir),
        .flag_clr_i(clr), .cap1_o(cap1), .cap2_o(cap2), .cap_flag_o(flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cnt <= cnt + 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Move the pin at a falling edge; return the count due to be captured
    task automatic drive_pin(input logic lvl, output logic [CNT_W-1:0] c);
        @(negedge clk) pin = lvl;
        repeat (3) @(posedge clk);
        #2 c = cnt;
    endtask

    task automatic pulse_clear();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [CNT_W-1:0] cr, cf;
        repeat (4) @(posedge clk);
        #2;
        chk("R1 cap1 in reset", 32'(cap1), 0);
        chk("R1 cap2 in reset", 32'(cap2), 0);
        chk("R1 flag in reset", 32'(flag), 0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            logic [8:0] v;
            v = VEC[i];
            @(negedge clk);
            sel = v[8:7]; dual = v[6]; dir = v[5];
            pulse_clear();
            drive_pin(1'b1, cr);
            drive_pin(1'b0, cf);
            if (v[4:3] == 2'd1) exp1 = cr;
            else if (v[4:3] == 2'd2) exp1 = cf;
            if (v[2:1] == 2'd1) exp2 = cr;
            else if (v[2:1] == 2'd2) exp2 = cf;
            chk($sformatf("R2-row%0d cap1 (R3 R4 R5 R6 R8)", i), 32'(cap1), 32'(exp1));
            chk($sformatf("R9 row%0d cap2 (R10)", i), 32'(cap2), 32'(exp2));
            chk($sformatf("R8 row%0d flag (R9)", i), 32'(flag), 32'(v[0]));
        end

        // R11: clear strobe coincides with an event, which is dropped
        @(negedge clk);
        sel = 2'd3; dual = 1'b0; dir = 1'b1;
        pulse_clear();
        @(negedge clk) pin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) clr = 1'b1;
        @(posedge clk);
        @(negedge clk) clr = 1'b0;
        chk("R11 coincident event dropped flag", 32'(flag), 0);
        chk("R11 coincident event dropped cap1", 32'(cap1), 32'(exp1));

        // R7: nothing moves after two edges, capture on the third
        @(negedge clk) pin = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk("R7 flag before third edge", 32'(flag), 0);
        chk("R7 cap1 before third edge", 32'(cap1), 32'(exp1));
        @(posedge clk);
        #2 exp1 = cnt;
        chk("R7 R11 re-armed capture value", 32'(cap1), 32'(exp1));
        chk("R7 flag at third edge", 32'(flag), 1);

        // R12: values held over idle cycles
        repeat (20) @(posedge clk);
        #2;
        chk("R12 cap1 held", 32'(cap1), 32'(exp1));
        chk("R12 cap2 held", 32'(cap2), 32'(exp2));
        pulse_clear();
        #1;
        chk("R11 flag cleared", 32'(flag), 0);
        finish_run();
    end
endmodule